// File: doc/BRIEF.md
# Ethernet MAC Host Register Interface

This block is the byte-wide register file through which a host processor configures an Ethernet media access controller. The host reaches it over a simple synchronous bus: a 5-bit register offset, a read strobe, a write strobe, an 8-bit write data bus and an 8-bit read data bus. Read data is combinational from the offset while the read strobe is high. Any side effect of a read or a write takes place at the clock edge that ends the access.

The block holds these registers:
- a receive control byte;
- an interrupt status byte that is set by event pulses from the MAC datapath and is cleared by reading it;
- an interrupt mask;
- a bus configuration byte whose soft reset bit acknowledges itself;
- a MAC configuration byte;
- a fixed 16-bit chip identifier.

An address configuration byte opens one of two load windows. Through one window the host writes a 64-bit multicast hash filter one byte at a time. Through the other it writes the 48-bit station address one byte at a time. Both windows share one auto-incrementing byte pointer. Both address values leave the block as parallel outputs, and an interrupt line summarises the unmasked status bits.

Top module: `eth_mac_regif`

## Requirements
- R1: After reset, offset 5 reads 0x01; offsets 8, 9, 11, 13 and 18 read 0x00; the interrupt line is low; both address outputs are zero.
- R2: Offsets 5 (receive control), 9 (interrupt mask) and 13 (MAC configuration) store all eight written bits and return them on read.
- R3: A read of offset 8 returns the current interrupt status, and the status becomes zero at that edge. An event bit that arrives in the same cycle as the read remains set afterwards.
- R4: A one-cycle pulse on bit n of the event input sets status bit n, and the bit holds until offset 8 is read.
- R5: The interrupt line is high exactly when some status bit is 1 while its mask bit is 0.
- R6: A write to offset 11 stores bits 7..1 as written, and stores bit 0 (soft reset request) as 0.
- R7: Offset 16 returns the low byte of the CHIP_ID parameter and offset 17 returns its high byte (default 0x0941).
- R8: At offset 18, bit 1 enables filter loading, bit 2 enables station loading, and bit 7 is stored as written. A write that sets bits 1 and 2 together stores bit 2 as 0. A write that leaves bit 1 or bit 2 set resets the shared byte pointer to 0.
- R9: While bit 1 of offset 18 is set, each write to offset 20 fills filter byte lane [pointer], bits 8p+7..8p, and then advances the pointer. The 8th such write clears bit 1 and returns the pointer to 0.
- R10: While bit 2 of offset 18 is set, each write to offset 21 fills station byte lane [pointer] in the same way. The 6th such write clears bit 2 and returns the pointer to 0.
- R11: A write to offset 20 while bit 1 is clear, or a write to offset 21 while bit 2 is clear, changes neither address output.
- R12: Offsets other than 5, 8, 9, 11, 13, 16, 17 and 18 read as 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_off | input | 5 | Register offset of the access |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, zero when rd_en is low |
| irq_evt | input | 8 | One-cycle interrupt event pulses, one per status bit |
| irq_out | output | 1 | Unmasked interrupt summary |
| station_addr | output | 48 | Station address, byte lane 0 in bits 7..0 |
| mcast_filter | output | 64 | Multicast hash filter, byte lane 0 in bits 7..0 |

## Verification
The hardest case to reach is the pointer shared by the two load windows. It has to be caught partway through a load and then restarted. The stimulus opens the station window, writes two bytes, and rewrites offset 18 to restart the load. It then writes a full six bytes and checks that the new bytes begin at lane 0 and that the window closes after the sixth byte. A second sequence raises an event pulse in the same cycle as a status read, to show that the event survives the clear.

// File: rtl/eth_regif_pkg.sv
package eth_regif_pkg;

  localparam int REG_OFF_W = 5;
  localparam int BYTE_W    = 8;

  typedef enum logic [REG_OFF_W-1:0] {
    OFF_RXCTL   = 5'd5,
    OFF_ISTAT   = 5'd8,
    OFF_IMASK   = 5'd9,
    OFF_BUSCFG  = 5'd11,
    OFF_MACCFG  = 5'd13,
    OFF_ID_LO   = 5'd16,
    OFF_ID_HI   = 5'd17,
    OFF_ADDRCFG = 5'd18,
    OFF_MFILT   = 5'd20,
    OFF_STADDR  = 5'd21
  } reg_off_e;

  localparam int SRST_BIT   = 0;
  localparam int MF_EN_BIT  = 1;
  localparam int ST_EN_BIT  = 2;

  localparam logic [BYTE_W-1:0] RXCTL_RST = 8'h01;

  typedef struct packed {
    logic rxctl;
    logic istat_rd;
    logic imask;
    logic buscfg;
    logic maccfg;
    logic addrcfg;
    logic mfilt;
    logic staddr;
  } acc_sel_t;

endpackage

// File: rtl/regif_cfg.sv
module regif_cfg
  import eth_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxctl_we,
  input  logic              buscfg_we,
  input  logic              maccfg_we,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rxctl_q,
  output logic [BYTE_W-1:0] buscfg_q,
  output logic [BYTE_W-1:0] maccfg_q
);

  logic [BYTE_W-1:0] rxctl_d, buscfg_d, maccfg_d;
  logic [BYTE_W-1:0] srst_clr_mask;

  assign srst_clr_mask = ~(BYTE_W'(1) << SRST_BIT);

  always_comb begin
    rxctl_d  = rxctl_we  ? wdata                 : rxctl_q;
    buscfg_d = buscfg_we ? (wdata & srst_clr_mask) : buscfg_q;
    maccfg_d = maccfg_we ? wdata                 : maccfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxctl_q  <= RXCTL_RST;
      buscfg_q <= '0;
      maccfg_q <= '0;
    end else begin
      rxctl_q  <= rxctl_d;
      buscfg_q <= buscfg_d;
      maccfg_q <= maccfg_d;
    end
  end

endmodule

// File: rtl/regif_irq.sv
module regif_irq
  import eth_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] evt,
  input  logic              stat_rd,
  input  logic              mask_we,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] stat_q,
  output logic [BYTE_W-1:0] mask_q,
  output logic              irq
);

  logic [BYTE_W-1:0] stat_d, mask_d, stat_kept;

  always_comb begin
    stat_kept = stat_rd ? '0 : stat_q;
    stat_d    = stat_kept | evt;
    mask_d    = mask_we ? wdata : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= stat_d;
      mask_q <= mask_d;
    end
  end

  assign irq = |(stat_q & ~mask_q);

endmodule

// File: rtl/regif_addr_ctl.sv
module regif_addr_ctl
  import eth_regif_pkg::*;
#(
  parameter int MF_BYTES = 8,
  parameter int ST_BYTES = 6,
  parameter int PTR_W    = $clog2(MF_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              mf_we,
  input  logic              st_we,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] cfg_q,
  output logic [PTR_W-1:0]  ptr_q,
  output logic              mf_load,
  output logic              st_load
);

  localparam logic [PTR_W-1:0] MF_LAST = PTR_W'(MF_BYTES - 1);
  localparam logic [PTR_W-1:0] ST_LAST = PTR_W'(ST_BYTES - 1);

  logic [BYTE_W-1:0] cfg_d, cfg_wval;
  logic [PTR_W-1:0]  ptr_d;

  assign mf_load = mf_we & cfg_q[MF_EN_BIT];
  assign st_load = st_we & cfg_q[ST_EN_BIT];

  // Filter loading wins when software asks for both windows at once.
  always_comb begin
    cfg_wval = wdata;
    if (wdata[MF_EN_BIT] && wdata[ST_EN_BIT]) begin
      cfg_wval[ST_EN_BIT] = 1'b0;
    end
  end

  always_comb begin
    cfg_d = cfg_q;
    ptr_d = ptr_q;
    if (cfg_we) begin
      cfg_d = cfg_wval;
      if (cfg_wval[MF_EN_BIT] || cfg_wval[ST_EN_BIT]) begin
        ptr_d = '0;
      end
    end else if (mf_load) begin
      if (ptr_q == MF_LAST) begin
        cfg_d[MF_EN_BIT] = 1'b0;
        ptr_d            = '0;
      end else begin
        ptr_d = ptr_q + 1'b1;
      end
    end else if (st_load) begin
      if (ptr_q == ST_LAST) begin
        cfg_d[ST_EN_BIT] = 1'b0;
        ptr_d            = '0;
      end else begin
        ptr_d = ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      ptr_q <= '0;
    end else begin
      cfg_q <= cfg_d;
      ptr_q <= ptr_d;
    end
  end

endmodule

// File: rtl/regif_lane_bank.sv
module regif_lane_bank
  import eth_regif_pkg::*;
#(
  parameter int NBYTES = 8,
  parameter int PTR_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [PTR_W-1:0]         ptr,
  input  logic [BYTE_W-1:0]        wdata,
  output logic [NBYTES*BYTE_W-1:0] value
);

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    logic              lane_en;
    logic [BYTE_W-1:0] lane_d, lane_q;

    assign lane_en = load && (ptr == PTR_W'(g));

    always_comb begin
      lane_d = lane_en ? wdata : lane_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q <= '0;
      end else begin
        lane_q <= lane_d;
      end
    end

    assign value[g*BYTE_W +: BYTE_W] = lane_q;
  end

endmodule

// File: rtl/eth_mac_regif.sv
module eth_mac_regif
  import eth_regif_pkg::*;
#(
  parameter logic [15:0] CHIP_ID  = 16'h0941,
  parameter int          MF_BYTES = 8,
  parameter int          ST_BYTES = 6,
  parameter int          SYNC_STG = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [REG_OFF_W-1:0]       reg_off,
  input  logic                       rd_en,
  input  logic                       wr_en,
  input  logic [BYTE_W-1:0]          wr_data,
  output logic [BYTE_W-1:0]          rd_data,
  input  logic [BYTE_W-1:0]          irq_evt,
  output logic                       irq_out,
  output logic [ST_BYTES*BYTE_W-1:0] station_addr,
  output logic [MF_BYTES*BYTE_W-1:0] mcast_filter
);

  localparam int PTR_W = $clog2(MF_BYTES);

  // Reset: asserted at once, released through a synchroniser chain.
  logic [SYNC_STG-1:0] rst_sync_q;
  logic                rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STG-2:0], 1'b1};
    end
  end

  assign rst_core_n = rst_sync_q[SYNC_STG-1];

  // Access decode.
  acc_sel_t sel;

  always_comb begin
    sel          = '0;
    sel.rxctl    = wr_en && (reg_off == OFF_RXCTL);
    sel.istat_rd = rd_en && (reg_off == OFF_ISTAT);
    sel.imask    = wr_en && (reg_off == OFF_IMASK);
    sel.buscfg   = wr_en && (reg_off == OFF_BUSCFG);
    sel.maccfg   = wr_en && (reg_off == OFF_MACCFG);
    sel.addrcfg  = wr_en && (reg_off == OFF_ADDRCFG);
    sel.mfilt    = wr_en && (reg_off == OFF_MFILT);
    sel.staddr   = wr_en && (reg_off == OFF_STADDR);
  end

  logic [BYTE_W-1:0] rxctl_q, buscfg_q, maccfg_q;
  logic [BYTE_W-1:0] istat_q, imask_q, addrcfg_q;
  logic [PTR_W-1:0]  addr_ptr_q;
  logic              mf_load, st_load;

  regif_cfg u_cfg (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .rxctl_we  (sel.rxctl),
    .buscfg_we (sel.buscfg),
    .maccfg_we (sel.maccfg),
    .wdata     (wr_data),
    .rxctl_q   (rxctl_q),
    .buscfg_q  (buscfg_q),
    .maccfg_q  (maccfg_q)
  );

  regif_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .evt     (irq_evt),
    .stat_rd (sel.istat_rd),
    .mask_we (sel.imask),
    .wdata   (wr_data),
    .stat_q  (istat_q),
    .mask_q  (imask_q),
    .irq     (irq_out)
  );

  regif_addr_ctl #(
    .MF_BYTES (MF_BYTES),
    .ST_BYTES (ST_BYTES),
    .PTR_W    (PTR_W)
  ) u_addr_ctl (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .cfg_we  (sel.addrcfg),
    .mf_we   (sel.mfilt),
    .st_we   (sel.staddr),
    .wdata   (wr_data),
    .cfg_q   (addrcfg_q),
    .ptr_q   (addr_ptr_q),
    .mf_load (mf_load),
    .st_load (st_load)
  );

  regif_lane_bank #(
    .NBYTES (MF_BYTES),
    .PTR_W  (PTR_W)
  ) u_mfilt_bank (
    .clk   (clk),
    .rst_n (rst_core_n),
    .load  (mf_load),
    .ptr   (addr_ptr_q),
    .wdata (wr_data),
    .value (mcast_filter)
  );

  regif_lane_bank #(
    .NBYTES (ST_BYTES),
    .PTR_W  (PTR_W)
  ) u_staddr_bank (
    .clk   (clk),
    .rst_n (rst_core_n),
    .load  (st_load),
    .ptr   (addr_ptr_q),
    .wdata (wr_data),
    .value (station_addr)
  );

  // Read mux.
  logic [BYTE_W-1:0] rd_mux;

  always_comb begin
    case (reg_off)
      OFF_RXCTL:   rd_mux = rxctl_q;
      OFF_ISTAT:   rd_mux = istat_q;
      OFF_IMASK:   rd_mux = imask_q;
      OFF_BUSCFG:  rd_mux = buscfg_q;
      OFF_MACCFG:  rd_mux = maccfg_q;
      OFF_ID_LO:   rd_mux = CHIP_ID[7:0];
      OFF_ID_HI:   rd_mux = CHIP_ID[15:8];
      OFF_ADDRCFG: rd_mux = addrcfg_q;
      default:     rd_mux = '0;
    endcase
  end

  assign rd_data = rd_en ? rd_mux : '0;

endmodule

// File: rtl/regif_checker.sv
module regif_checker
  import eth_regif_pkg::*;
#(
  parameter logic [15:0] CHIP_ID  = 16'h0941,
  parameter int          MF_BYTES = 8,
  parameter int          ST_BYTES = 6,
  parameter int          PTR_W    = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [REG_OFF_W-1:0]       reg_off,
  input logic                       rd_en,
  input logic                       wr_en,
  input logic [BYTE_W-1:0]          wr_data,
  input logic [BYTE_W-1:0]          rd_data,
  input logic [BYTE_W-1:0]          irq_evt,
  input logic                       irq_out,
  input logic [BYTE_W-1:0]          int_stat,
  input logic [BYTE_W-1:0]          int_mask,
  input logic [BYTE_W-1:0]          bus_cfg,
  input logic [BYTE_W-1:0]          addr_cfg,
  input logic [PTR_W-1:0]           addr_ptr,
  input logic [ST_BYTES*BYTE_W-1:0] station_addr,
  input logic [MF_BYTES*BYTE_W-1:0] mcast_filter
);

  logic impl_off;
  assign impl_off = reg_off inside {5'd5, 5'd8, 5'd9, 5'd11, 5'd13,
                                    5'd16, 5'd17, 5'd18};

  assert_isr_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_off == OFF_ISTAT) |=> (int_stat == $past(irq_evt)));

  assert_evt_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_evt) |=> ((int_stat & $past(irq_evt)) == $past(irq_evt)));

  assert_irq_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((int_stat & ~int_mask) == '0) |-> !irq_out);

  assert_irq_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(int_stat & ~int_mask)) |-> irq_out);

  assert_srst_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_off == OFF_BUSCFG) |=> (bus_cfg == ($past(wr_data) & 8'hFE)));

  assert_id_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_off == OFF_ID_LO) |-> (rd_data == CHIP_ID[7:0]));

  assert_id_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_off == OFF_ID_HI) |-> (rd_data == CHIP_ID[15:8]));

  assert_one_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_cfg[MF_EN_BIT] && addr_cfg[ST_EN_BIT]));

  assert_st_ptr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    addr_cfg[ST_EN_BIT] |-> (addr_ptr < PTR_W'(ST_BYTES)));

  assert_st_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_off == OFF_STADDR && !addr_cfg[ST_EN_BIT]) |=> $stable(station_addr));

  assert_mf_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_off == OFF_MFILT && !addr_cfg[MF_EN_BIT]) |=> $stable(mcast_filter));

  assert_unimpl_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !impl_off) |-> (rd_data == '0));

endmodule

bind eth_mac_regif regif_checker #(
  .CHIP_ID  (CHIP_ID),
  .MF_BYTES (MF_BYTES),
  .ST_BYTES (ST_BYTES),
  .PTR_W    (PTR_W)
) u_regif_chk (
  .clk          (clk),
  .rst_n        (rst_core_n),
  .reg_off      (reg_off),
  .rd_en        (rd_en),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .rd_data      (rd_data),
  .irq_evt      (irq_evt),
  .irq_out      (irq_out),
  .int_stat     (istat_q),
  .int_mask     (imask_q),
  .bus_cfg      (buscfg_q),
  .addr_cfg     (addrcfg_q),
  .addr_ptr     (addr_ptr_q),
  .station_addr (station_addr),
  .mcast_filter (mcast_filter)
);

// File: tb/test_eth_mac_regif.sv
module test_eth_mac_regif;

  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC       = 16;

  // {is_write, offset, data, expected read, requirement number}
  localparam logic [25:0] VEC [NVEC] = '{
    {1'b1, 5'd5,  8'hA5, 8'h00, 4'd2},
    {1'b0, 5'd5,  8'h00, 8'hA5, 4'd2},   // R2 receive control
    {1'b1, 5'd9,  8'h3C, 8'h00, 4'd2},
    {1'b0, 5'd9,  8'h00, 8'h3C, 4'd2},   // R2 mask
    {1'b1, 5'd13, 8'h81, 8'h00, 4'd2},
    {1'b0, 5'd13, 8'h00, 8'h81, 4'd2},   // R2 MAC configuration
    {1'b1, 5'd11, 8'h5B, 8'h00, 4'd6},
    {1'b0, 5'd11, 8'h00, 8'h5A, 4'd6},   // R6 soft reset acknowledged
    {1'b1, 5'd11, 8'hFF, 8'h00, 4'd6},
    {1'b0, 5'd11, 8'h00, 8'hFE, 4'd6},   // R6
    {1'b0, 5'd16, 8'h00, 8'h41, 4'd7},   // R7 low byte
    {1'b0, 5'd17, 8'h00, 8'h09, 4'd7},   // R7 high byte
    {1'b1, 5'd3,  8'hFF, 8'h00, 4'd12},
    {1'b0, 5'd3,  8'h00, 8'h00, 4'd12},  // R12 unimplemented offset
    {1'b1, 5'd18, 8'h86, 8'h00, 4'd8},
    {1'b0, 5'd18, 8'h00, 8'h82, 4'd8}    // R8 bit 2 dropped, bit 7 kept
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  reg_off;
  logic        rd_en, wr_en;
  logic [7:0]  wr_data, rd_data, irq_evt;
  logic        irq_out;
  logic [47:0] station_addr;
  logic [63:0] mcast_filter;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eth_mac_regif i_eth_mac_regif (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_off      (reg_off),
    .rd_en        (rd_en),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .irq_evt      (irq_evt),
    .irq_out      (irq_out),
    .station_addr (station_addr),
    .mcast_filter (mcast_filter)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] off, logic [7:0] d);
    @(negedge clk);
    reg_off = off; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(logic [4:0] off, logic [7:0] exp, string req);
    @(negedge clk);
    reg_off = off; rd_en = 1'b1;
    #1;
    check(req, 64'(rd_data), 64'(exp));
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse(logic [7:0] v);
    @(negedge clk);
    irq_evt = v;
    @(negedge clk);
    irq_evt = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_off = '0; rd_en = 1'b0; wr_en = 1'b0;
    wr_data = '0; irq_evt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_chk(5'd5,  8'h01, "R1");
    rd_chk(5'd8,  8'h00, "R1");
    rd_chk(5'd9,  8'h00, "R1");
    rd_chk(5'd11, 8'h00, "R1");
    rd_chk(5'd13, 8'h00, "R1");
    rd_chk(5'd18, 8'h00, "R1");
    check("R1", 64'(irq_out), 64'd0);
    check("R1", 64'(station_addr), 64'd0);
    check("R1", mcast_filter, 64'd0);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][25]) begin
        wr(VEC[i][24:20], VEC[i][19:12]);
      end else begin
        rd_chk(VEC[i][24:20], VEC[i][11:4], $sformatf("R%0d", VEC[i][3:0]));
      end
    end
    // R12 the write to offset 3 left the other registers alone
    rd_chk(5'd5, 8'hA5, "R12");
    rd_chk(5'd13, 8'h81, "R12");

    // R4 / R5 / R3 interrupts
    wr(5'd9, 8'hFE);
    pulse(8'h02);
    check("R5 masked", 64'(irq_out), 64'd0);
    rd_chk(5'd9, 8'hFE, "R2");
    pulse(8'h01);
    check("R5 unmasked", 64'(irq_out), 64'd1);
    rd_chk(5'd8, 8'h03, "R4");
    check("R3 cleared line", 64'(irq_out), 64'd0);
    rd_chk(5'd8, 8'h00, "R3");
    // R3 event in the same cycle as the read survives
    @(negedge clk);
    reg_off = 5'd8; rd_en = 1'b1; irq_evt = 8'h10;
    #1;
    check("R3 same-cycle read", 64'(rd_data), 64'd0);
    @(negedge clk);
    rd_en = 1'b0; irq_evt = '0;
    rd_chk(5'd8, 8'h10, "R3");

    // R9 filter load (window already open from the table)
    wr(5'd18, 8'h02);
    for (int b = 0; b < 8; b++) wr(5'd20, 8'(b + 1));
    check("R9 filter", mcast_filter, 64'h0807060504030201);
    rd_chk(5'd18, 8'h00, "R9");
    wr(5'd20, 8'hFF);
    check("R11 filter closed", mcast_filter, 64'h0807060504030201);
    wr(5'd21, 8'h77);
    check("R11 station closed", 64'(station_addr), 64'd0);

    // R10 station load
    wr(5'd18, 8'h04);
    for (int b = 0; b < 6; b++) wr(5'd21, 8'(8'hA0 + b));
    check("R10 station", 64'(station_addr), 64'h0000A5A4A3A2A1A0);
    rd_chk(5'd18, 8'h00, "R10");

    // R8 pointer restart partway through a load
    wr(5'd18, 8'h04);
    wr(5'd21, 8'h11);
    wr(5'd21, 8'h22);
    check("R8 partial", 64'(station_addr), 64'h0000A5A4A3A22211);
    wr(5'd18, 8'h04);
    for (int b = 0; b < 6; b++) wr(5'd21, 8'(8'hB0 + b));
    check("R8 restart", 64'(station_addr), 64'h0000B5B4B3B2B1B0);
    rd_chk(5'd18, 8'h00, "R8");

    // R11 station write while only the filter window is open
    wr(5'd18, 8'h02);
    wr(5'd21, 8'h55);
    check("R11 wrong window", 64'(station_addr), 64'h0000B5B4B3B2B1B0);
    wr(5'd20, 8'hC0);
    check("R9 lane 0", mcast_filter, 64'h08070605040302C0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule